// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is a minimal processor datapath in which every register transfer travels over one shared internal bus. Eight general-purpose registers, a program counter, an instruction register, a memory address register, a memory data register and an increment register each have a load control. Every register that can be a bus source also has a drive control. A fixed control sequencer steps through an instruction fetch and then through either an indirect load or an indirect store. It raises exactly the drive and load controls that each step needs.

Memory is reached through a request handshake. The address always comes from the memory address register and write data from the memory data register. A read or write strobe rises when its step begins and stays high, with address and write data frozen, until the memory answers with a one-cycle completion pulse. The completion pulse is sampled on the same clock edge that ends the step, and read data must be valid in that cycle. Memory may take any number of cycles to answer, and the sequencer waits without limit. The drive-control vector is brought out so that integration checks can observe bus ownership.

Instruction word (low byte used): bits [7:6] opcode, bits [5:3] address-register index `ra`, bits [2:0] data-register index `rd`. Opcode 01 loads `rd` from memory at the address held in `ra`. Opcode 10 stores `rd` to memory at the address held in `ra`. Opcodes 00 and 11 do nothing beyond the fetch.

Top module: `sbus_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter and all registers to 0 and returns the sequencer to its first fetch step. While reset is held, both strobes are low and the address is 0. The first access after release is an instruction read at address 0.
- R2: Every instruction fetch is a read whose address equals the current program counter. The returned word becomes the instruction.
- R3: Each completed fetch advances the program counter by 4, so successive fetch addresses are 0, 4, 8 and so on.
- R4: Once a read or write strobe rises, the sequencer holds its step and keeps the strobe high until the cycle in which completion is seen. The strobe is low in the following cycle. This holds for any completion latency from 1 cycle upward.
- R5: Opcode 01 performs a read at the address held in `ra` and places the returned word in `rd`.
- R6: Opcode 10 performs a write at the address held in `ra`, carrying the value of `rd` as data.
- R7: In every cycle, at most one bus source has its drive control active.
- R8: Opcodes 00 and 11 cause no data access: the next memory access is the fetch at the following word.
- R9: The read and write strobes are never high together.
- R10: While a strobe waits for completion, the address and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Memory address, from the memory address register |
| mem_rd | output | 1 | Read strobe, held until completion |
| mem_wr | output | 1 | Write strobe, held until completion |
| mem_wdata | output | 32 | Write data, from the memory data register |
| mem_rdata | input | 32 | Read data, valid in the completion cycle |
| mem_mfc | input | 1 | One-cycle memory completion pulse |
| bus_oe | output | 11 | Bus drive controls: [7:0] general registers, [8] program counter, [9] data register, [10] increment register |

## Verification
A short program chains indirect loads, so that each loaded word becomes the next address. This separates a correct indirect path from one that reads the wrong register or the wrong field. A store of a register through itself, and stores after the loads, show whether the data register ends up on the bus. Both no-operation opcodes sit between the stores, which exposes any extra data access or a skipped program counter step. The same program runs with completion latency fixed at 1 cycle, fixed at 5 cycles and random per access, to separate a correct stall from one that advances early or lingers. A reset in the middle of a program shows that fetching restarts cleanly from 0.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    ST_F0, // program counter to address register, increment computed
    ST_F1, // instruction read, wait completion
    ST_F2, // data register to instruction register
    ST_F3, // increment register to program counter, dispatch
    ST_E0, // address register operand to memory address register
    ST_E1, // load: data read / store: data operand to data register
    ST_E2  // load: data register to target / store: write, wait completion
  } step_t;

  localparam logic [1:0] OP_LOAD  = 2'b01;
  localparam logic [1:0] OP_STORE = 2'b10;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mdr_out;
    logic mdr_ld_bus;
    logic mdr_ld_mem;
    logic z_out;
    logic z_in;
    logic mar_in;
    logic ir_in;
    logic gpr_out;
    logic gpr_in;
    logic use_ra;
    logic mem_rd;
    logic mem_wr;
  } ctrl_t;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 8,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [RIW-1:0]             ld_idx,
  input  logic [W-1:0]               din,
  output logic [NREGS-1:0][W-1:0]    q
);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                 q[g] <= '0;
      else if (ld_en && ld_idx == RIW'(g))     q[g] <= din;
    end
  end

endmodule

// File: rtl/sbus_bus.sv
module sbus_bus #(
  parameter int W    = 32,
  parameter int NSRC = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          oe,
  input  logic [NSRC-1:0][W-1:0]   src,
  output logic [W-1:0]             bus
);

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      bus = bus | (oe[i] ? src[i] : '0);
    end
  end

  // R7: single bus owner per cycle
  p_one_driver_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(oe))
    else $error("R7: more than one bus driver");

endmodule

// File: rtl/sbus_seq.sv
module sbus_seq
  import sbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] op,
  input  logic       mem_mfc,
  output step_t      step,
  output ctrl_t      ctrl
);

  step_t nxt;

  always_ff @(posedge clk) begin
    if (rst) step <= ST_F0;
    else     step <= nxt;
  end

  always_comb begin
    nxt  = step;
    ctrl = '0;
    unique case (step)
      ST_F0: begin
        ctrl.pc_out = 1'b1; ctrl.mar_in = 1'b1; ctrl.z_in = 1'b1;
        nxt = ST_F1;
      end
      ST_F1: begin
        ctrl.mem_rd = 1'b1; ctrl.mdr_ld_mem = 1'b1;
        if (mem_mfc) nxt = ST_F2;
      end
      ST_F2: begin
        ctrl.mdr_out = 1'b1; ctrl.ir_in = 1'b1;
        nxt = ST_F3;
      end
      ST_F3: begin
        ctrl.z_out = 1'b1; ctrl.pc_in = 1'b1;
        nxt = (op == OP_LOAD || op == OP_STORE) ? ST_E0 : ST_F0;
      end
      ST_E0: begin
        ctrl.gpr_out = 1'b1; ctrl.use_ra = 1'b1; ctrl.mar_in = 1'b1;
        nxt = ST_E1;
      end
      ST_E1: begin
        if (op == OP_LOAD) begin
          ctrl.mem_rd = 1'b1; ctrl.mdr_ld_mem = 1'b1;
          if (mem_mfc) nxt = ST_E2;
        end else begin
          ctrl.gpr_out = 1'b1; ctrl.mdr_ld_bus = 1'b1;
          nxt = ST_E2;
        end
      end
      ST_E2: begin
        if (op == OP_LOAD) begin
          ctrl.mdr_out = 1'b1; ctrl.gpr_in = 1'b1;
          nxt = ST_F0;
        end else begin
          ctrl.mem_wr = 1'b1;
          if (mem_mfc) nxt = ST_F0;
        end
      end
      default: nxt = ST_F0;
    endcase
  end

  // R4: a waiting strobe freezes the step
  p_step_stall_r4: assert property (@(posedge clk) disable iff (rst)
    ((ctrl.mem_rd || ctrl.mem_wr) && !mem_mfc) |=> $stable(step))
    else $error("R4: step moved before completion");

  // R8: a no-operation instruction returns to fetch
  p_nop_refetch_r8: assert property (@(posedge clk) disable iff (rst)
    (step == ST_F3 && (op == 2'b00 || op == 2'b11)) |=> step == ST_F0)
    else $error("R8: no-operation did not return to fetch");

endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int W       = 32,
  parameter int NREGS   = 8,
  parameter int PC_STEP = 4,
  localparam int RIW    = $clog2(NREGS),
  localparam int IRW    = 2 * RIW + 2,
  localparam int NSRC   = NREGS + 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [W-1:0]     mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata,
  input  logic             mem_mfc,
  output logic [NSRC-1:0]  bus_oe
);

  localparam int SRC_PC  = NREGS;
  localparam int SRC_MDR = NREGS + 1;
  localparam int SRC_Z   = NREGS + 2;

  step_t                    step;
  ctrl_t                    ctrl;
  logic [W-1:0]             bus;
  logic [W-1:0]             pc_q, mar_q, mdr_q, z_q;
  logic [IRW-1:0]           ir_q;
  logic [NREGS-1:0][W-1:0]  gpr_q;
  logic [NSRC-1:0][W-1:0]   src;
  logic [NREGS-1:0]         gpr_oe;
  logic [RIW-1:0]           ra_f, rd_f, out_idx;
  logic [1:0]               op_f;

  assign rd_f    = ir_q[RIW-1:0];
  assign ra_f    = ir_q[2*RIW-1:RIW];
  assign op_f    = ir_q[IRW-1:2*RIW];
  assign out_idx = ctrl.use_ra ? ra_f : rd_f;

  sbus_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .op      (op_f),
    .mem_mfc (mem_mfc),
    .step    (step),
    .ctrl    (ctrl)
  );

  sbus_regfile #(.W(W), .NREGS(NREGS)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ctrl.gpr_in),
    .ld_idx (rd_f),
    .din    (bus),
    .q      (gpr_q)
  );

  assign gpr_oe = ctrl.gpr_out ? (NREGS'(1) << out_idx) : '0;
  assign bus_oe = {ctrl.z_out, ctrl.mdr_out, ctrl.pc_out, gpr_oe};

  assign src[NREGS-1:0] = gpr_q;
  assign src[SRC_PC]    = pc_q;
  assign src[SRC_MDR]   = mdr_q;
  assign src[SRC_Z]     = z_q;

  sbus_bus #(.W(W), .NSRC(NSRC)) u_bus (
    .clk (clk),
    .rst (rst),
    .oe  (bus_oe),
    .src (src),
    .bus (bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      z_q   <= '0;
      ir_q  <= '0;
    end else begin
      if (ctrl.pc_in)  pc_q  <= bus;
      if (ctrl.mar_in) mar_q <= bus;
      if (ctrl.z_in)   z_q   <= bus + W'(PC_STEP);
      if (ctrl.ir_in)  ir_q  <= bus[IRW-1:0];
      if (ctrl.mdr_ld_mem && mem_mfc) mdr_q <= mem_rdata;
      else if (ctrl.mdr_ld_bus)       mdr_q <= bus;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = ctrl.mem_rd;
  assign mem_wr    = ctrl.mem_wr;

  // R9
  p_rdwr_excl_r9: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr))
    else $error("R9: read and write together");

  // R3: program counter moves one word per fetch
  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl.pc_in |=> pc_q == $past(pc_q) + W'(PC_STEP))
    else $error("R3: program counter step wrong");

  // R2: fetch address is the program counter
  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (step == ST_F1) |-> mem_addr == pc_q)
    else $error("R2: fetch address differs from program counter");

  // R10 (and R4): pending request stays frozen
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_mfc) |=>
      (mem_rd == $past(mem_rd)) && (mem_wr == $past(mem_wr)) &&
      $stable(mem_addr) && $stable(mem_wdata))
    else $error("R10: request changed while waiting");

endmodule

// File: tb/sim_sbus_core.sv
module sim_sbus_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_rd, mem_wr;
  logic        mem_mfc = 1'b0;
  logic [10:0] bus_oe;

  always #4 clk = ~clk;

  sbus_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .bus_oe(bus_oe)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [31:0] mem [0:63];
  logic        log_wr   [0:31];
  logic [31:0] log_addr [0:31];
  logic [31:0] log_data [0:31];
  int n_acc = 0;
  int fixed_lat = 0;
  int err_drop = 0, err_hold = 0, err_stab = 0, err_excl = 0, err_bus = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder and monitors, driven on the falling edge
  initial begin
    int w = 0, lat = 1;
    logic [31:0] la = '0, lw = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_mfc = 1'b0; w = 0;
      end else begin
        if ($countones(bus_oe) > 1) err_bus++;
        if (mem_rd && mem_wr) err_excl++;
        if (mem_mfc) begin
          mem_mfc = 1'b0;
          if (mem_rd || mem_wr) err_hold++;
        end else if (mem_rd || mem_wr) begin
          if (w == 0) lat = (fixed_lat > 0) ? fixed_lat : $urandom_range(1, 5);
          else if (mem_addr !== la || mem_wdata !== lw) err_stab++;
          la = mem_addr; lw = mem_wdata;
          w++;
          if (w == lat) begin
            if (mem_rd) mem_rdata = mem[mem_addr[7:2]];
            else        mem[mem_addr[7:2]] = mem_wdata;
            if (n_acc < 32) begin
              log_wr[n_acc]   = mem_wr;
              log_addr[n_acc] = mem_addr;
              log_data[n_acc] = mem_rd ? mem[mem_addr[7:2]] : mem_wdata;
            end
            n_acc++;
            mem_mfc = 1'b1;
            w = 0;
          end
        end else if (w > 0) begin
          err_drop++;
          w = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  function automatic logic [31:0] enc(input logic [1:0] op, input logic [2:0] ra, input logic [2:0] rd);
    return {24'h0, op, ra, rd};
  endfunction

  task automatic load_prog();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = enc(2'b01, 3'd0, 3'd1); // r1 <- [r0]   (= 0x41)
    mem[1]  = enc(2'b01, 3'd1, 3'd2); // r2 <- [r1]
    mem[2]  = enc(2'b01, 3'd2, 3'd3); // r3 <- [r2]
    mem[3]  = enc(2'b10, 3'd1, 3'd3); // [r1] <- r3
    mem[4]  = enc(2'b00, 3'd5, 3'd6); // no-op
    mem[5]  = enc(2'b11, 3'd7, 3'd7); // no-op
    mem[6]  = enc(2'b10, 3'd2, 3'd2); // [r2] <- r2
    mem[16] = 32'h0000_00A0;
    mem[40] = 32'hCAFE_F00D;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr, "R1 strobes in reset", {30'h0, mem_rd, mem_wr}, 32'h0);
    chk(mem_addr == 32'h0, "R1 address in reset", mem_addr, 32'h0);
    n_acc = 0; err_drop = 0; err_hold = 0; err_stab = 0; err_excl = 0; err_bus = 0;
    rst = 1'b0;
  endtask

  task automatic wait_acc(input int n);
    int t = 0;
    while (n_acc < n && t < 3000) begin @(negedge clk); t++; end
    chk(n_acc >= n, "access count", n_acc, n);
  endtask

  task automatic chk_acc(input int i, input bit wr, input logic [31:0] a, input logic [31:0] d, input string req);
    chk(log_wr[i] == wr, req, {31'h0, log_wr[i]}, {31'h0, wr});
    chk(log_addr[i] == a, req, log_addr[i], a);
    chk(log_data[i] == d, req, log_data[i], d);
  endtask

  task automatic chk_errs();
    chk(err_drop == 0 && err_hold == 0, "R4 strobe hold", err_drop + err_hold, 0);
    chk(err_stab == 0, "R10 request stable", err_stab, 0);
    chk(err_excl == 0, "R9 strobes exclusive", err_excl, 0);
    chk(err_bus == 0, "R7 single bus driver", err_bus, 0);
  endtask

  task automatic t_program(input int lat);
    fixed_lat = lat;
    load_prog();
    do_reset();
    wait_acc(13);
    chk_acc(0,  0, 32'h00, 32'h41,        "R1 R2 first fetch at 0");
    chk_acc(1,  0, 32'h00, 32'h41,        "R5 load via r0");
    chk_acc(2,  0, 32'h04, 32'h4A,        "R3 fetch 4");
    chk_acc(3,  0, 32'h41, 32'hA0,        "R5 load via r1");
    chk_acc(4,  0, 32'h08, 32'h53,        "R3 fetch 8");
    chk_acc(5,  0, 32'hA0, 32'hCAFEF00D,  "R5 load via r2");
    chk_acc(6,  0, 32'h0C, 32'h8B,        "R2 fetch store");
    chk_acc(7,  1, 32'h41, 32'hCAFEF00D,  "R6 store r3 via r1");
    chk_acc(8,  0, 32'h10, 32'h2E,        "R8 fetch no-op 00");
    chk_acc(9,  0, 32'h14, 32'hFF,        "R8 fetch no-op 11");
    chk_acc(10, 0, 32'h18, 32'h92,        "R8 no data access after no-op");
    chk_acc(11, 1, 32'hA0, 32'hA0,        "R6 store r2 via r2");
    chk_acc(12, 0, 32'h1C, 32'h00,        "R3 fetch after store");
    chk_errs();
  endtask

  task automatic t_midreset();
    fixed_lat = 3;
    load_prog();
    do_reset();
    wait_acc(5);
    do_reset();
    wait_acc(3);
    chk_acc(0, 0, 32'h00, 32'h41, "R1 restart fetch at 0");
    chk_acc(1, 0, 32'h00, 32'h41, "R1 registers cleared");
    chk_acc(2, 0, 32'h04, 32'h4A, "R1 R3 fetch 4 after restart");
    chk_errs();
  endtask

  initial begin
    t_program(1);
    t_program(5);
    t_program(0);
    t_midreset();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule